// File: doc/BRIEF.md
# Masked Real-Time Response Comparator

This block checks the sampled response of a 64-pin group against the expected vector while a pattern burst runs. Each clock cycle can carry one vector. A vector consists of the captured response word, the expected word, its vector address and its own compare-enable bit. A static per-pin mask removes don't-care pins from every comparison.

The block has three result paths:
- A registered per-pin fail word and an error flag give the result for each vector.
- An error record latches the address of the first failing vector and counts failing vectors with a counter that saturates.
- In stop-on-error mode, a failing vector also raises a halt request towards the pattern sequencer. The request stays high until the host clears the record.

In tag-on-error mode the burst runs on and only the record is updated.

Top module: `rt_compare`

## Requirements
- R1: For a valid vector with compare enabled, the fail word is (actual XOR expected) AND NOT mask. Bit i of the fail word belongs to pin i. The fail word appears on the clock edge after the vector is presented.
- R2: A pin whose mask bit is 1 never sets its fail bit. It never raises the error flag, counts a failure or raises a halt request, on any vector.
- R3: A vector with compare-enable low, or a cycle with the vector-valid strobe low, gives an all-zero fail word and changes neither the tag nor the count.
- R4: The error flag is 1 exactly when the registered fail word is non-zero, in the same cycle.
- R5: With stop-on-error high, a failing vector raises the halt request on the following edge. The request stays high until a record clear, even if the mode later changes.
- R6: With stop-on-error low, failing vectors update the tag and count but never raise the halt request. Comparison continues on every later vector.
- R7: The address of the first failing vector since reset or the last clear is latched, and the tag-valid output is set. Later failures do not change the latched address.
- R8: A record-clear pulse zeroes tag-valid, the fail count and the halt request on the next edge. A failing vector in the same cycle as the clear starts a fresh record: it sets tag-valid, latches its own address and sets the count to 1.
- R9: The fail count adds one per failing vector and holds at 2^COUNT_W-1 instead of wrapping.
- R10: After reset, the fail word, error flag, tag-valid, tag address, fail count and halt request are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pattern-rate clock; response data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vecValid | input | 1 | A vector is presented this cycle |
| cmpEnable | input | 1 | Per-vector compare-enable bit |
| actualData | input | PINS | Captured response of the pin group |
| expectData | input | PINS | Expected response for this vector |
| pinMask | input | PINS | Static don't-care mask, 1 = ignore pin |
| vecAddr | input | ADDR_W | Address of the presented vector |
| stopOnError | input | 1 | 1 = halt on error, 0 = tag and continue |
| tagClear | input | 1 | Host pulse clearing tag, count and halt |
| failWord | output | PINS | Registered per-pin mismatch word |
| errFlag | output | 1 | OR of the fail word |
| tagValid | output | 1 | An error record is held |
| tagAddr | output | ADDR_W | Address of the first failing vector |
| failCount | output | COUNT_W | Saturating count of failing vectors |
| haltReq | output | 1 | Halt request to the sequencer |

## Verification
Every result of this block lands on the first rising edge after the vector or clear pulse is presented: the fail word, error flag, tag, count and halt request. None of them takes a second cycle. The bench therefore drives each vector on a falling edge and waits for exactly one rising edge. It samples one time unit later, before the next falling edge can apply new inputs. Checks that a masked or disabled vector has no effect read the tag, count and halt outputs in that same window. Saturation is reached with a narrow count width.

// File: rtl/rt_compare_pkg.sv
package rt_compare_pkg;

  // Strobes issued by the record control to the datapath registers.
  typedef struct packed {
    logic clearRec;    // zero the fail counter this edge
    logic captureTag;  // load the tag address register
    logic incCount;    // one failing vector to add
  } cmpStrobe_t;

  typedef enum logic [1:0] {
    REC_IDLE   = 2'd0,
    REC_TAGGED = 2'd1,
    REC_HALTED = 2'd2
  } recState_t;

endpackage

// File: rtl/rt_compare_dp.sv
module rt_compare_dp
  import rt_compare_pkg::*;
#(
  parameter int PINS    = 64,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 20,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vecValid,
  input  logic               cmpEnable,
  input  logic [PINS-1:0]    actualData,
  input  logic [PINS-1:0]    expectData,
  input  logic [PINS-1:0]    pinMask,
  input  logic [ADDR_W-1:0]  vecAddr,
  input  cmpStrobe_t         strobe,
  output logic               anyFail,
  output logic [PINS-1:0]    failWord,
  output logic               errFlag,
  output logic [ADDR_W-1:0]  tagAddr,
  output logic [COUNT_W-1:0] failCount
);

  localparam int LANES = PINS / LANE_W;
  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] COUNT_ONE = {{(COUNT_W-1){1'b0}}, 1'b1};

  logic              checkGate;
  logic [PINS-1:0]   failNext;
  logic [LANES-1:0]  laneHit;

  assign checkGate = vecValid & cmpEnable;

  // Compare is split into lanes so the OR tree stays shallow per lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneDiff;
    assign laneDiff = (actualData[g*LANE_W +: LANE_W] ^ expectData[g*LANE_W +: LANE_W])
                      & ~pinMask[g*LANE_W +: LANE_W];
    assign failNext[g*LANE_W +: LANE_W] = checkGate ? laneDiff : '0;
    assign laneHit[g] = |failNext[g*LANE_W +: LANE_W];
  end

  assign anyFail = |laneHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failWord <= '0;
      errFlag  <= 1'b0;
    end else begin
      failWord <= failNext;
      errFlag  <= anyFail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tagAddr <= '0;
    end else if (strobe.captureTag) begin
      tagAddr <= vecAddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failCount <= '0;
    end else if (strobe.clearRec) begin
      failCount <= strobe.incCount ? COUNT_ONE : '0;
    end else if (strobe.incCount && (failCount != COUNT_MAX)) begin
      failCount <= failCount + COUNT_ONE;
    end
  end

  // R2: masked pins stay silent
  assert_mask_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((failWord & $past(pinMask)) == '0));

  // R3: disabled or idle vector yields no fail bits
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(vecValid) && $past(cmpEnable)) |-> (failWord == '0));

  // R4: flag tracks the registered word
  assert_flag_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag == (failWord != '0));

  // R9: counter never wraps
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(failCount) == COUNT_MAX && !$past(strobe.clearRec)) |-> (failCount == COUNT_MAX));

endmodule

// File: rtl/rt_compare_ctl.sv
module rt_compare_ctl
  import rt_compare_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyFail,
  input  logic       stopOnError,
  input  logic       tagClear,
  output cmpStrobe_t strobe,
  output logic       tagValid,
  output logic       haltReq
);

  recState_t recState, recNext;

  always_comb begin
    strobe.clearRec   = tagClear;
    strobe.incCount   = anyFail;
    strobe.captureTag = anyFail && (tagClear || recState == REC_IDLE);

    recNext = recState;
    if (tagClear) begin
      if (anyFail) recNext = stopOnError ? REC_HALTED : REC_TAGGED;
      else         recNext = REC_IDLE;
    end else if (anyFail) begin
      if (stopOnError || recState == REC_HALTED) recNext = REC_HALTED;
      else                                       recNext = REC_TAGGED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recState <= REC_IDLE;
    else        recState <= recNext;
  end

  assign tagValid = (recState != REC_IDLE);
  assign haltReq  = (recState == REC_HALTED);

  // R6: a halt only ever starts from stop-on-error mode
  assert_halt_needs_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(haltReq) |-> $past(stopOnError));

  // R5: halt is sticky until cleared
  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(haltReq) && !$past(tagClear)) |-> haltReq);

  // R5: a halt always comes with a held tag
  assert_halt_has_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    haltReq |-> tagValid);

endmodule

// File: rtl/rt_compare.sv
module rt_compare
  import rt_compare_pkg::*;
#(
  parameter int PINS    = 64,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 20,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vecValid,
  input  logic               cmpEnable,
  input  logic [PINS-1:0]    actualData,
  input  logic [PINS-1:0]    expectData,
  input  logic [PINS-1:0]    pinMask,
  input  logic [ADDR_W-1:0]  vecAddr,
  input  logic               stopOnError,
  input  logic               tagClear,
  output logic [PINS-1:0]    failWord,
  output logic               errFlag,
  output logic               tagValid,
  output logic [ADDR_W-1:0]  tagAddr,
  output logic [COUNT_W-1:0] failCount,
  output logic               haltReq
);

  cmpStrobe_t strobe;
  logic       anyFail;

  rt_compare_dp #(
    .PINS(PINS), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .vecValid(vecValid), .cmpEnable(cmpEnable),
    .actualData(actualData), .expectData(expectData), .pinMask(pinMask),
    .vecAddr(vecAddr), .strobe(strobe), .anyFail(anyFail),
    .failWord(failWord), .errFlag(errFlag),
    .tagAddr(tagAddr), .failCount(failCount)
  );

  rt_compare_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .anyFail(anyFail), .stopOnError(stopOnError), .tagClear(tagClear),
    .strobe(strobe), .tagValid(tagValid), .haltReq(haltReq)
  );

  // R7: held tag address is not overwritten by later failures
  assert_tag_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tagValid) && !$past(tagClear)) |-> (tagValid && $stable(tagAddr)));

endmodule

// File: tb/rt_compare_tb.sv
module rt_compare_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PINS    = 64;
  localparam int ADDR_W  = 16;
  localparam int COUNT_W = 4;
  localparam int NVEC    = 7;

  localparam logic [63:0] T_ACT [NVEC] = '{
    64'h0, 64'hFF, 64'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234,
    64'h8000_0000_0000_0001, 64'hA5A5_A5A5_A5A5_A5A5 };
  localparam logic [63:0] T_EXP [NVEC] = '{
    64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h1, 64'h5A5A_5A5A_5A5A_5A5A };
  localparam logic [63:0] T_MSK [NVEC] = '{
    64'h0, 64'h0, 64'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
    64'h0, 64'hFFFF_0000_0000_0000 };
  localparam logic T_EN [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [63:0] T_FAIL [NVEC] = '{
    64'h0, 64'hFF, 64'hF0, 64'h0, 64'h0,
    64'h8000_0000_0000_0000, 64'h0000_FFFF_FFFF_FFFF };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vecValid = 1'b0, cmpEnable = 1'b0, stopOnError = 1'b0, tagClear = 1'b0;
  logic [PINS-1:0] actualData = '0, expectData = '0, pinMask = '0;
  logic [ADDR_W-1:0] vecAddr = '0;
  logic [PINS-1:0] failWord;
  logic errFlag, tagValid, haltReq;
  logic [ADDR_W-1:0] tagAddr;
  logic [COUNT_W-1:0] failCount;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_compare #(.PINS(PINS), .LANE_W(8), .ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .vecValid(vecValid), .cmpEnable(cmpEnable),
    .actualData(actualData), .expectData(expectData), .pinMask(pinMask),
    .vecAddr(vecAddr), .stopOnError(stopOnError), .tagClear(tagClear),
    .failWord(failWord), .errFlag(errFlag), .tagValid(tagValid),
    .tagAddr(tagAddr), .failCount(failCount), .haltReq(haltReq));

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, sample 1 unit after it.
  task automatic step(input logic v, input logic en, input logic [63:0] a,
                      input logic [63:0] e, input logic [63:0] m,
                      input logic [ADDR_W-1:0] ad, input logic clr);
    @(negedge clk);
    vecValid = v; cmpEnable = en; actualData = a; expectData = e;
    pinMask = m; vecAddr = ad; tagClear = clr;
    @(posedge clk);
    #1;
    vecValid = 1'b0; tagClear = 1'b0;
  endtask

  task automatic checkRecord(input string req, input logic tv, input logic [ADDR_W-1:0] ta,
                             input logic [COUNT_W-1:0] cnt, input logic h);
    check(req, "tagValid", 64'(tagValid), 64'(tv));
    if (tv) check(req, "tagAddr", 64'(tagAddr), 64'(ta));
    check(req, "failCount", 64'(failCount), 64'(cnt));
    check(req, "haltReq", 64'(haltReq), 64'(h));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", "failWord", failWord, 64'h0);
    check("R10", "errFlag", 64'(errFlag), 64'h0);
    checkRecord("R10", 1'b0, '0, '0, 1'b0);
    check("R10", "tagAddr", 64'(tagAddr), 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: R1/R2/R3/R4 fail word and flag
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, T_EN[i], T_ACT[i], T_EXP[i], T_MSK[i], ADDR_W'(100 + i), 1'b0);
      check("R1", $sformatf("failWord vec %0d", i), failWord, T_FAIL[i]);
      check("R4", $sformatf("errFlag vec %0d", i), 64'(errFlag), 64'(T_FAIL[i] != 0));
    end
    // four failing table vectors (1,2,5,6), first at 101, tag mode
    checkRecord("R6", 1'b1, ADDR_W'(101), 4'd4, 1'b0);

    // R8: clear alone
    step(1'b0, 1'b0, '0, '0, '0, '0, 1'b1);
    checkRecord("R8", 1'b0, '0, 4'd0, 1'b0);

    // R7: first failing address kept; R6 no halt in tag mode
    step(1'b1, 1'b1, 64'h5, 64'h5, '0, ADDR_W'(10), 1'b0);
    step(1'b1, 1'b1, 64'h4, 64'h5, '0, ADDR_W'(11), 1'b0);
    step(1'b1, 1'b1, 64'h0, 64'h5, '0, ADDR_W'(12), 1'b0);
    checkRecord("R7", 1'b1, ADDR_W'(11), 4'd2, 1'b0);

    // R3: mismatching data with valid low, then with enable low, has no effect
    step(1'b0, 1'b1, 64'hFF, 64'h0, '0, ADDR_W'(13), 1'b0);
    check("R3", "failWord valid low", failWord, 64'h0);
    step(1'b1, 1'b0, 64'hFF, 64'h0, '0, ADDR_W'(14), 1'b0);
    checkRecord("R3", 1'b1, ADDR_W'(11), 4'd2, 1'b0);

    // R5: stop mode halts after clear
    step(1'b0, 1'b0, '0, '0, '0, '0, 1'b1);
    stopOnError = 1'b1;
    // R2: a masked-only mismatch in stop mode raises nothing
    step(1'b1, 1'b1, 64'hF0, 64'h0, 64'hF0, ADDR_W'(19), 1'b0);
    checkRecord("R2", 1'b0, '0, 4'd0, 1'b0);
    step(1'b1, 1'b1, 64'h1, 64'h0, '0, ADDR_W'(20), 1'b0);
    checkRecord("R5", 1'b1, ADDR_W'(20), 4'd1, 1'b1);
    stopOnError = 1'b0;
    step(1'b1, 1'b1, 64'h2, 64'h0, '0, ADDR_W'(21), 1'b0);
    check("R6", "compare continues", failWord, 64'h2);
    checkRecord("R5", 1'b1, ADDR_W'(20), 4'd2, 1'b1);

    // R8: clear together with a failing vector starts a fresh record
    step(1'b1, 1'b1, 64'h8, 64'h0, '0, ADDR_W'(30), 1'b1);
    checkRecord("R8", 1'b1, ADDR_W'(30), 4'd1, 1'b0);

    // R9: saturation at 15
    step(1'b0, 1'b0, '0, '0, '0, '0, 1'b1);
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 64'h1, 64'h0, '0, ADDR_W'(40 + k), 1'b0);
    checkRecord("R9", 1'b1, ADDR_W'(40), 4'd15, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule